// File: doc/BRIEF.md
# SPI Transmit/Receive Queue Register Block

This block sits between a simple register bus and an SPI frame engine. Software writes bytes into a transmit queue and reads received bytes out of a receive queue, both through single data registers. The engine takes transmit bytes through a valid/pop handshake and hands received bytes back through a push strobe. Each queue's status travels in bit 31 of its own data register. A read of the transmit register reports whether that queue is full. A read of the receive register returns a byte, or reports that the queue is empty, in the same access that pops it.

Two watermark registers turn the queue levels into two pending flags. Transmit pending means the transmit level is under its mark. Receive pending means the receive level is over its mark. An enable register masks these flags into a single interrupt line. Software can therefore wait for "N words received" by setting the receive mark to N−1, or for "transmit drained" by leaving the transmit mark at 1.

Top module: `spiq_regs`

## Requirements
- R1: After reset the interrupt enable reads 0, the transmit mark reads 1, the receive mark reads 0, both queues are empty and `irq` is low.
- R2: A register write to offset 0x48 enqueues `reg_wdata[7:0]`. The engine sees the bytes on `tx_data` with `tx_valid` high, in write order, and one byte leaves per cycle in which `tx_pop` is high.
- R3: A read of offset 0x48 returns bit 31 set when the transmit queue holds DEPTH bytes, clear otherwise, and all other bits 0.
- R4: A write to offset 0x48 while the transmit queue is full is discarded and never reaches the engine.
- R5: A read of offset 0x4C with data present returns the oldest received byte in bits 7:0 with bit 31 clear, and removes it from the queue.
- R6: A read of offset 0x4C with the receive queue empty returns 0x8000_0000 and leaves the queue state unchanged.
- R7: `rx_ready` is low while the receive queue is full, and an `rx_push` in that state is discarded.
- R8: Bit 0 of the read-only register at offset 0x74 is 1 exactly when the transmit level is below the mark at offset 0x50.
- R9: Bit 1 of offset 0x74 is 1 exactly when the receive level is above the mark at offset 0x54.
- R10: Offset 0x70 holds two enable bits (bit 0 transmit, bit 1 receive). `irq` is high exactly when some enabled pending bit is 1.
- R11: Read data appears on `reg_rdata` in the cycle after the read strobe. Offsets 0x50, 0x54 and 0x70 read back their stored values, and an unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_re` |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_data | output | DATA_W | Oldest transmit byte |
| tx_pop | input | 1 | Engine takes the transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
The bench builds the block with DEPTH set to 4 rather than 8. Both queues therefore reach full within a handful of accesses, which puts the full flag, the dropped write and the dropped engine push within reach of short sequences. The transmit mark can also span every level from empty to full. With the smaller depth, the pending flags are checked on both sides of each mark, and the pointers are driven through several wraps.

// File: rtl/spiq_pkg.sv
package spiq_pkg;

    localparam logic [7:0] OFS_TXD  = 8'h48;
    localparam logic [7:0] OFS_RXD  = 8'h4C;
    localparam logic [7:0] OFS_TXMK = 8'h50;
    localparam logic [7:0] OFS_RXMK = 8'h54;
    localparam logic [7:0] OFS_IEN  = 8'h70;
    localparam logic [7:0] OFS_IPND = 8'h74;

    typedef struct packed {
        logic rx;
        logic tx;
    } spiq_evt_t;

    function automatic logic [31:0] flag_word(input logic flag);
        return {flag, 31'b0};
    endfunction

endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/spiq_wmark.sv
module spiq_wmark
    import spiq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [CNT_W-1:0] tx_mark,
    input  logic [CNT_W-1:0] rx_mark,
    input  spiq_evt_t        ien,
    output spiq_evt_t        pend,
    output logic             irq
);
    always_comb begin
        pend.tx = (tx_cnt < tx_mark);
        pend.rx = (rx_cnt > rx_mark);
        irq     = |(ien & pend);
    end
endmodule

// File: rtl/spiq_regs.sv
module spiq_regs
    import spiq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0]  tx_cnt, rx_cnt, tx_mark, rx_mark;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    spiq_evt_t         ien, pend;
    logic [31:0]       rd_next;

    logic sel_txd, sel_rxd, sel_txmk, sel_rxmk, sel_ien, sel_ipnd;
    assign sel_txd  = (reg_addr == ADDR_W'(OFS_TXD));
    assign sel_rxd  = (reg_addr == ADDR_W'(OFS_RXD));
    assign sel_txmk = (reg_addr == ADDR_W'(OFS_TXMK));
    assign sel_rxmk = (reg_addr == ADDR_W'(OFS_RXMK));
    assign sel_ien  = (reg_addr == ADDR_W'(OFS_IEN));
    assign sel_ipnd = (reg_addr == ADDR_W'(OFS_IPND));

    spiq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) tx_q_i (
        .clk(clk), .rst(rst),
        .push(reg_we && sel_txd), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spiq_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) rx_q_i (
        .clk(clk), .rst(rst),
        .push(rx_push), .din(rx_data),
        .pop(reg_re && sel_rxd), .dout(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spiq_wmark #(.CNT_W(CNT_W)) wm_i (
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_mark(tx_mark), .rx_mark(rx_mark),
        .ien(ien), .pend(pend), .irq(irq)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mark <= CNT_W'(1);
            rx_mark <= '0;
            ien     <= '0;
        end else if (reg_we) begin
            if (sel_txmk) tx_mark <= reg_wdata[CNT_W-1:0];
            if (sel_rxmk) rx_mark <= reg_wdata[CNT_W-1:0];
            if (sel_ien)  ien     <= reg_wdata[1:0];
        end
    end

    always_comb begin
        rd_next = '0;
        if (sel_txd)       rd_next = flag_word(tx_full);
        else if (sel_rxd)  rd_next = rx_empty ? flag_word(1'b1) : 32'(rx_head);
        else if (sel_txmk) rd_next = 32'(tx_mark);
        else if (sel_rxmk) rd_next = 32'(rx_mark);
        else if (sel_ien)  rd_next = {30'b0, ien};
        else if (sel_ipnd) rd_next = {30'b0, pend};
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_next;
    end
endmodule

// File: rtl/spiq_regs_chk.sv
module spiq_regs_chk
    import spiq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic              reg_re,
    input logic [31:0]       reg_rdata,
    input logic              tx_pop,
    input logic              rx_push,
    input logic              irq,
    input logic              rx_ready,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [1:0]        ien
);
    logic rd_tx, rd_rx, wr_tx;
    assign rd_tx = reg_re && (reg_addr == ADDR_W'(OFS_TXD));
    assign rd_rx = reg_re && (reg_addr == ADDR_W'(OFS_RXD));
    assign wr_tx = reg_we && (reg_addr == ADDR_W'(OFS_TXD));

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tx_cnt == '0 && rx_cnt == '0 && ien == 2'b00));

    a_r3_full_flag: assert property (@(posedge clk) disable iff (rst)
        rd_tx |=> reg_rdata == {$past(tx_cnt == CNT_W'(DEPTH)), 31'b0});

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && tx_cnt == CNT_W'(DEPTH) && !tx_pop) |=> tx_cnt == CNT_W'(DEPTH));

    a_r6_empty_word: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_cnt == '0) |=> reg_rdata == 32'h8000_0000);

    a_r6_empty_no_pop: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);

    a_r7_rx_drop: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_cnt == CNT_W'(DEPTH) && !rd_rx) |=> rx_cnt == CNT_W'(DEPTH));

    a_r7_ready_low: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt == CNT_W'(DEPTH)) |-> !rx_ready);

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq);
endmodule

bind spiq_regs spiq_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata), .tx_pop(tx_pop), .rx_push(rx_push), .irq(irq),
    .rx_ready(rx_ready), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ien(ien)
);

// File: tb/spiq_regs_tb_top.sv
`timescale 1ns/1ps
module spiq_regs_tb_top;
    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_pop = 1'b0;
    logic [7:0]  tx_data;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, irq;

    int errors = 0, checks = 0;
    bit drain_en = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #2 clk = ~clk;

    spiq_regs #(.DEPTH(D), .DATA_W(8), .ADDR_W(8)) dut_i (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1'b1;
        @(negedge clk); reg_re = 1'b0; d = reg_rdata;
    endtask

    task automatic send(input logic [7:0] b, input bit accepted);
        wr(8'h48, b);
        if (accepted) tx_q.push_back(b);
    endtask

    task automatic eng_push(input logic [7:0] b, input bit accepted);
        @(negedge clk); rx_push = 1'b1; rx_data = b;
        @(negedge clk); rx_push = 1'b0;
        if (accepted) rx_q.push_back(b);
    endtask

    task automatic drain();
        @(posedge clk); drain_en = 1'b1;
        while (tx_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        @(posedge clk); drain_en = 1'b0;
        @(negedge clk);
        check("R4 no stray byte after drain", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic rx_read_expect();
        logic [31:0] v;
        logic [7:0]  e;
        rd(8'h4C, v);
        if (rx_q.size() == 0) check("R6 empty read", v, 32'h8000_0000);
        else begin e = rx_q.pop_front(); check("R5 rx byte", v, {24'b0, e}); end
    endtask

    // monitor: engine side of the transmit queue
    always @(negedge clk) begin
        if (drain_en && tx_valid) begin
            checks++;
            if (tx_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R4 unexpected byte got=%h exp=none", tx_data);
            end else begin
                logic [7:0] e;
                e = tx_q.pop_front();
                if (tx_data !== e) begin
                    errors++;
                    $display("FAIL R2 tx order got=%h exp=%h", tx_data, e);
                end
            end
            tx_pop = 1'b1;
        end else tx_pop = 1'b0;
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog got=%0d exp=<20000", cyc);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h70, v); check("R1 ien reset", v, 32'h0);
        rd(8'h50, v); check("R1 tx mark reset", v, 32'h1);
        rd(8'h54, v); check("R1 rx mark reset", v, 32'h0);
        rd(8'h48, v); check("R1 tx not full", v, 32'h0);
        rd(8'h74, v); check("R8 empty tx pending", v, 32'h1);
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        rx_read_expect();

        // R2/R3/R4 fill, overflow, drain
        send(8'hA1, 1); send(8'hA2, 1); send(8'hA3, 1);
        rd(8'h48, v); check("R3 not yet full", v, 32'h0);
        send(8'hA4, 1);
        rd(8'h48, v); check("R3 full flag", v, 32'h8000_0000);
        rd(8'h74, v); check("R8 tx above mark", v, 32'h0);
        send(8'hEE, 0);
        drain();
        rd(8'h74, v); check("R8 drained", v, 32'h1);

        // R8 mark at 3, second wrap
        wr(8'h50, 8'h03);
        rd(8'h50, v); check("R11 tx mark readback", v, 32'h3);
        send(8'h5A, 1); send(8'hC3, 1);
        rd(8'h74, v); check("R8 two below three", v, 32'h1);
        send(8'h0F, 1);
        rd(8'h74, v); check("R8 three not below three", v, 32'h0);
        drain();

        // R10 enable mask
        wr(8'h70, 8'hFF);
        rd(8'h70, v); check("R11 ien readback", v, 32'h3);
        check("R10 irq on tx pending", {31'b0, irq}, 32'h1);
        wr(8'h70, 8'h02);
        check("R10 tx masked", {31'b0, irq}, 32'h0);

        // R9/R5 receive watermark and data
        wr(8'h54, 8'h02);
        eng_push(8'h11, 1); eng_push(8'h22, 1);
        rd(8'h74, v); check("R9 two not above two", v, 32'h1);
        check("R10 irq low rx", {31'b0, irq}, 32'h0);
        eng_push(8'h33, 1);
        rd(8'h74, v); check("R9 three above two", v, 32'h3);
        check("R10 irq on rx pending", {31'b0, irq}, 32'h1);
        rx_read_expect(); rx_read_expect(); rx_read_expect();
        rx_read_expect();
        rx_read_expect();
        eng_push(8'h44, 1);
        rx_read_expect();
        rx_read_expect();

        // R7 receive overflow
        wr(8'h54, 8'h00);
        eng_push(8'h61, 1); eng_push(8'h62, 1); eng_push(8'h63, 1); eng_push(8'h64, 1);
        check("R7 ready low when full", {31'b0, rx_ready}, 32'h0);
        eng_push(8'h65, 0);
        rx_read_expect(); rx_read_expect(); rx_read_expect(); rx_read_expect();
        rx_read_expect();
        check("R7 ready after drain", {31'b0, rx_ready}, 32'h1);

        // R11 unmapped offset
        rd(8'h00, v); check("R11 unmapped", v, 32'h0);
        rd(8'h54, v); check("R11 rx mark readback", v, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule